// File: doc/BRIEF.md
# Segment Protection and Translation Selector

This block sits on the memory access path between address generation and the cache. Each access arrives as a linear address, a byte count and an access kind. The block checks the access against the current segment's permissions and bounds. It then decides how the physical address is formed: either the linear address is passed through unchanged, or the translation supplied by the TLB lookup is used. When the TLB reports a miss, a miss fault is raised instead.

The result is registered. One cycle after a request, a single valid strobe presents either a physical address or a fault code. When there is a fault, an information word goes with it.

Segment bounds checks cover three cases:
- ordinary segments;
- segments whose limit lies below their base, so the valid region wraps;
- segments that grow downward.

All segment checks are skipped when the core is running 64-bit code.

Top module: `seg_xlate_gate`

## Requirements
- R1: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high, and low otherwise. A synchronous active-low reset clears it.
- R2: `rsp_fault` encodes the result: 2'b00 means no fault, 2'b01 means segment protection fault and 2'b10 means TLB miss. `rsp_info` carries a different value for each:
  - no fault: the physical address;
  - protection fault: error code 0;
  - TLB miss: the linear address.
- R3: Segment checks (R4 to R8) apply only when `prot_en` is high and `long_active` and `cs_long` are not both high.
- R4: A write (`req_kind` 2'b01) to a segment with `seg_wr_ok` low raises a protection fault.
- R5: A read (`req_kind` 2'b00) of a segment with `seg_rd_ok` low raises a protection fault. An execute access (`req_kind` 2'b10 or 2'b11) is never checked against `seg_rd_ok`.
- R6: For a segment that does not grow down and whose limit is below its base, an access faults when limit < addr+size and addr < base.
- R7: For a segment that does not grow down and whose limit is at or above its base, an access faults when addr < base or addr+size > limit+1.
- R8: For a segment that grows down, an access faults when addr ≤ limit and addr+size ≥ base. All sums in R6 to R8 are computed without wraparound.
- R9: With `prot_en` and `paging_en` high and `tlb_hit` low, the access reports a TLB miss carrying the linear address.
- R10: On a TLB hit with paging on, the physical address is `tlb_pbase` OR (addr AND (2^`tlb_pg_lg2` − 1)).
- R11: With `prot_en` low (real mode), or with `paging_en` low, the physical address equals the linear address. In real mode `paging_en` and the TLB inputs have no effect.
- R12: A protection fault takes priority over a TLB miss. Only one fault code is reported per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | AW | Linear address |
| req_size | input | SZW | Access size in bytes |
| req_kind | input | 2 | 00 read, 01 write, 1x execute |
| seg_rd_ok | input | 1 | Segment readable |
| seg_wr_ok | input | 1 | Segment writable |
| seg_grow_down | input | 1 | Segment grows downward |
| seg_base | input | AW | Segment base |
| seg_limit | input | AW | Segment limit |
| prot_en | input | 1 | Protected mode enabled |
| paging_en | input | 1 | Paging enabled |
| long_active | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment is 64-bit |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_pbase | input | AW | Physical base of the hit entry |
| tlb_pg_lg2 | input | LGW | log2 of the hit entry's page size |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 2 | Fault code |
| rsp_info | output | AW | Physical address, error code or faulting address |

## Verification
The bench sweeps addresses and sizes across segments with wrapped, ordinary and grow-down bounds. Each access is compared against an arithmetic model. The sweep catches off-by-one errors at the limit and base edges: a design that compared against the limit instead of limit+1 would fault the last legal byte. A design that let the sum addr+size wrap would accept accesses that run past the top of the address space.

Directed cases cover the following:
- Execute accesses to unreadable segments, which a design that applied the read check to every access would wrongly fault.
- 64-bit code skipping the checks; a wrong design would raise faults there.
- Real mode with paging requested, where a wrong design would consult the TLB.
- Page-size merges at two sizes, where a fixed offset width would lose or corrupt upper offset bits.
- A protection fault combined with a TLB miss, where the wrong priority would report the miss.

// File: rtl/segx_pkg.sv
// Package: shared codes for the segment protection and translation selector.
// Assumes two-bit fault and access-kind fields at the block's ports.
package segx_pkg;
    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_PROT = 2'b01,
        FLT_MISS = 2'b10
    } segx_fault_e;

    localparam logic [1:0] KIND_READ  = 2'b00;
    localparam logic [1:0] KIND_WRITE = 2'b01;
endpackage

// File: rtl/segx_perm.sv
// Module: segx_perm
// Decides whether the access kind is permitted by the segment's read and
// write attributes. Execute accesses (kind 1x) are not checked here.
// Assumes the caller gates the result with the segment-check enable.
module segx_perm
    import segx_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       rd_ok,
    input  logic       wr_ok,
    output logic       perm_fault
);
    // Purpose: flag writes to read-only and reads of unreadable segments.
    always_comb begin
        perm_fault = 1'b0;
        if (kind == KIND_WRITE && !wr_ok) perm_fault = 1'b1;
        if (kind == KIND_READ  && !rd_ok) perm_fault = 1'b1;
    end
endmodule

// File: rtl/segx_bounds.sv
// Module: segx_bounds
// Checks an access span [addr, addr+size) against segment base and limit.
// Three cases: limit below base (wrapped region), ordinary, grow-down.
// Sums are formed one bit wider than the address so they never wrap.
module segx_bounds #(
    parameter int AW  = 32,
    parameter int SZW = 4
) (
    input  logic [AW-1:0]  addr,
    input  logic [SZW-1:0] size,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  limit,
    input  logic           grow_down,
    output logic           bound_fault
);
    localparam int EW = AW + 1;

    logic [EW-1:0] addr_x, base_x, limit_x, end_x, limit_p1;
    logic          wrapped;

    // Purpose: widen operands and form the end of the access span.
    always_comb begin
        addr_x   = {1'b0, addr};
        base_x   = {1'b0, base};
        limit_x  = {1'b0, limit};
        end_x    = addr_x + {{(EW-SZW){1'b0}}, size};
        limit_p1 = limit_x + {{(EW-1){1'b0}}, 1'b1};
        wrapped  = (limit < base);
    end

    // Purpose: select the bounds rule for the segment kind.
    always_comb begin
        if (grow_down) begin
            bound_fault = (addr_x <= limit_x) && (end_x >= base_x);
        end else if (wrapped) begin
            bound_fault = (limit_x < end_x) && (addr_x < base_x);
        end else begin
            bound_fault = (addr_x < base_x) || (end_x > limit_p1);
        end
    end
endmodule

// File: rtl/segx_route.sv
// Module: segx_route
// Chooses the physical address source (identity or TLB merge) and the
// final fault code. Protection faults take priority over TLB misses.
// Assumes tlb_pg_lg2 < AW.
module segx_route
    import segx_pkg::*;
#(
    parameter int AW  = 32,
    parameter int LGW = 5
) (
    input  logic           seg_fault,
    input  logic           prot_en,
    input  logic           paging_en,
    input  logic [AW-1:0]  addr,
    input  logic           tlb_hit,
    input  logic [AW-1:0]  tlb_pbase,
    input  logic [LGW-1:0] tlb_pg_lg2,
    output segx_fault_e    fault,
    output logic [AW-1:0]  info
);
    logic [AW-1:0] off_mask;

    // One comparator per address bit builds the page-offset mask.
    for (genvar i = 0; i < AW; i++) begin : g_mask
        assign off_mask[i] = (i < int'(tlb_pg_lg2));
    end

    // Purpose: pick the fault code and the word that goes with it.
    always_comb begin
        if (seg_fault) begin
            fault = FLT_PROT;
            info  = '0;
        end else if (!prot_en || !paging_en) begin
            fault = FLT_NONE;
            info  = addr;
        end else if (!tlb_hit) begin
            fault = FLT_MISS;
            info  = addr;
        end else begin
            fault = FLT_NONE;
            info  = tlb_pbase | (addr & off_mask);
        end
    end
endmodule

// File: rtl/seg_xlate_gate.sv
// Module: seg_xlate_gate (top)
// Segment permission and bounds check followed by translation selection,
// with a registered one-cycle response. Segment checks are enabled in
// protected mode unless 64-bit code is running.
module seg_xlate_gate
    import segx_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 4,
    parameter int LGW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    input  logic [SZW-1:0] req_size,
    input  logic [1:0]     req_kind,
    input  logic           seg_rd_ok,
    input  logic           seg_wr_ok,
    input  logic           seg_grow_down,
    input  logic [AW-1:0]  seg_base,
    input  logic [AW-1:0]  seg_limit,
    input  logic           prot_en,
    input  logic           paging_en,
    input  logic           long_active,
    input  logic           cs_long,
    input  logic           tlb_hit,
    input  logic [AW-1:0]  tlb_pbase,
    input  logic [LGW-1:0] tlb_pg_lg2,
    output logic           rsp_valid,
    output logic [1:0]     rsp_fault,
    output logic [AW-1:0]  rsp_info
);
    logic          perm_fault, bound_fault, seg_check_en, seg_fault;
    segx_fault_e   nxt_fault;
    logic [AW-1:0] nxt_info;

    segx_perm u_perm (
        .kind       (req_kind),
        .rd_ok      (seg_rd_ok),
        .wr_ok      (seg_wr_ok),
        .perm_fault (perm_fault)
    );

    segx_bounds #(.AW(AW), .SZW(SZW)) u_bounds (
        .addr        (req_addr),
        .size        (req_size),
        .base        (seg_base),
        .limit       (seg_limit),
        .grow_down   (seg_grow_down),
        .bound_fault (bound_fault)
    );

    // Purpose: enable segment checks outside 64-bit code in protected mode.
    always_comb begin
        seg_check_en = prot_en && !(long_active && cs_long);
        seg_fault    = seg_check_en && (perm_fault || bound_fault);
    end

    segx_route #(.AW(AW), .LGW(LGW)) u_route (
        .seg_fault  (seg_fault),
        .prot_en    (prot_en),
        .paging_en  (paging_en),
        .addr       (req_addr),
        .tlb_hit    (tlb_hit),
        .tlb_pbase  (tlb_pbase),
        .tlb_pg_lg2 (tlb_pg_lg2),
        .fault      (nxt_fault),
        .info       (nxt_info)
    );

    // Purpose: register the response; payload loads only with a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_info  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault <= nxt_fault;
                rsp_info  <= nxt_info;
            end
        end
    end
endmodule

// File: rtl/seg_xlate_gate_chk.sv
// Module: seg_xlate_gate_chk
// Temporal checks on the top module's ports, bound into every instance.
module seg_xlate_gate_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic [1:0]    req_kind,
    input logic          seg_wr_ok,
    input logic          prot_en,
    input logic          paging_en,
    input logic          long_active,
    input logic          cs_long,
    input logic          tlb_hit,
    input logic          rsp_valid,
    input logic [1:0]    rsp_fault,
    input logic [AW-1:0] rsp_info
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault != 2'b11); // R2
    AST_REAL_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !prot_en |=> rsp_fault == 2'b00 && rsp_info == $past(req_addr)); // R11
    AST_RO_WRITE_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && prot_en && !(long_active && cs_long) && req_kind == 2'b01 && !seg_wr_ok
        |=> rsp_fault == 2'b01 && rsp_info == '0); // R4
    AST_LONG_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && prot_en && long_active && cs_long |=> rsp_fault != 2'b01); // R3
    AST_MISS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && prot_en && paging_en && !tlb_hit |=> rsp_fault != 2'b00); // R9
endmodule

bind seg_xlate_gate seg_xlate_gate_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_kind    (req_kind),
    .seg_wr_ok   (seg_wr_ok),
    .prot_en     (prot_en),
    .paging_en   (paging_en),
    .long_active (long_active),
    .cs_long     (cs_long),
    .tlb_hit     (tlb_hit),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_info    (rsp_info)
);

// File: tb/seg_xlate_gate_test.sv
// Bench: small configuration (8-bit addresses), directed cases plus a
// sweep over bounds, compared against an arithmetic model.
module seg_xlate_gate_test;
    localparam int AW = 8, SZW = 3, LGW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0;
    logic [AW-1:0] req_addr = 0;
    logic [SZW-1:0] req_size = 1;
    logic [1:0] req_kind = 0;
    logic seg_rd_ok = 1, seg_wr_ok = 1, seg_grow_down = 0;
    logic [AW-1:0] seg_base = 0, seg_limit = 8'hFF;
    logic prot_en = 0, paging_en = 0, long_active = 0, cs_long = 0;
    logic tlb_hit = 0;
    logic [AW-1:0] tlb_pbase = 0;
    logic [LGW-1:0] tlb_pg_lg2 = 0;
    logic rsp_valid;
    logic [1:0] rsp_fault;
    logic [AW-1:0] rsp_info;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    seg_xlate_gate #(.AW(AW), .SZW(SZW), .LGW(LGW)) uut (.*);

    // Model built from the requirements.
    function automatic logic [AW+1:0] model();
        int a = int'(req_addr), e = int'(req_addr) + int'(req_size);
        int b = int'(seg_base), l = int'(seg_limit);
        logic gp = 1'b0;
        if (prot_en && !(long_active && cs_long)) begin
            if (req_kind == 2'b01 && !seg_wr_ok) gp = 1'b1;
            if (req_kind == 2'b00 && !seg_rd_ok) gp = 1'b1;
            if (seg_grow_down) begin
                if (a <= l && e >= b) gp = 1'b1;
            end else if (l < b) begin
                if (l < e && a < b) gp = 1'b1;
            end else begin
                if (a < b || e > l + 1) gp = 1'b1;
            end
        end
        if (gp) return {2'b01, {AW{1'b0}}};
        if (!prot_en || !paging_en) return {2'b00, req_addr};
        if (!tlb_hit) return {2'b10, req_addr};
        return {2'b00, tlb_pbase | AW'((1 << int'(tlb_pg_lg2)) - 1) & req_addr};
    endfunction

    task automatic check(input string tag, input logic [AW+1:0] act, input logic [AW+1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one access at the negedge, check the response at the next one.
    task automatic go(input string tag);
        logic [AW+1:0] exp;
        exp = model();
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, {{(AW+1){1'b0}}, rsp_valid}, {{(AW+1){1'b0}}, 1'b1});
        check(tag, {rsp_fault, rsp_info}, exp);
    endtask

    task automatic seg(input logic [AW-1:0] b, input logic [AW-1:0] l, input logic gd);
        seg_base = b; seg_limit = l; seg_grow_down = gd;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {{(AW+1){1'b0}}, rsp_valid}, '0);
        check("R1 reset payload", {rsp_fault, rsp_info}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", {{(AW+1){1'b0}}, rsp_valid}, '0);

        // R11 real mode ignores paging and TLB.
        prot_en = 0; paging_en = 1; tlb_hit = 0; req_addr = 8'h5A;
        go("R11 real mode");
        check("R11 real literal", {rsp_fault, rsp_info}, {2'b00, 8'h5A});
        // R11 paging off in protected mode.
        prot_en = 1; paging_en = 0; seg(8'h00, 8'hFF, 0); req_addr = 8'h33;
        go("R11 paging off");

        // R4 write to read-only segment, R2 error code 0.
        seg_wr_ok = 0; req_kind = 2'b01; go("R4 ro write");
        check("R2 prot code", {rsp_fault, rsp_info}, {2'b01, 8'h00});
        // R3 64-bit code skips checks; long_active alone does not.
        long_active = 1; cs_long = 1; go("R3 long skip");
        check("R3 long literal", {rsp_fault, rsp_info}, {2'b00, 8'h33});
        cs_long = 0; go("R3 compat checks");
        long_active = 0; seg_wr_ok = 1;

        // R5 read vs execute on unreadable segment.
        seg_rd_ok = 0; req_kind = 2'b00; go("R5 read unreadable");
        req_kind = 2'b10; go("R5 exec unreadable");
        check("R5 exec literal", {rsp_fault, rsp_info}, {2'b00, 8'h33});
        req_kind = 2'b11; go("R5 exec alt code");
        seg_rd_ok = 1; req_kind = 2'b00;

        // R7 limit edges, R6 wrapped, R8 grow-down.
        seg(8'h20, 8'h3F, 0); req_size = 4;
        req_addr = 8'h3C; go("R7 last legal");
        req_addr = 8'h3D; go("R7 one over");
        req_addr = 8'h1F; go("R7 below base");
        seg(8'hF0, 8'hFF, 0); req_addr = 8'hFE; req_size = 7; go("R7 no wrap sum");
        seg(8'hC0, 8'h40, 0); req_size = 2;
        req_addr = 8'h3F; go("R6 straddle limit");
        req_addr = 8'h10; go("R6 low ok");
        req_addr = 8'h80; go("R6 hole");
        seg(8'h20, 8'h60, 1);
        req_addr = 8'h60; go("R8 at limit");
        req_addr = 8'h61; go("R8 above limit");

        // R9 miss, R10 hit at two page sizes, R12 priority.
        seg(8'h00, 8'hFF, 0); paging_en = 1; req_size = 1; req_addr = 8'hB7;
        go("R9 miss");
        check("R9 miss literal", {rsp_fault, rsp_info}, {2'b10, 8'hB7});
        tlb_hit = 1; tlb_pbase = 8'h40; tlb_pg_lg2 = 2; go("R10 hit 4");
        check("R10 literal", {rsp_fault, rsp_info}, {2'b00, 8'h43});
        tlb_pbase = 8'h00; tlb_pg_lg2 = 5; go("R10 hit 32");
        tlb_hit = 0; seg_wr_ok = 0; req_kind = 2'b01; go("R12 prot over miss");
        seg_wr_ok = 1; req_kind = 2'b00;

        // R6/R7/R8 sweep with paging off.
        paging_en = 0;
        foreach (seg_base[i]) begin end
        for (int bi = 0; bi < 3; bi++) begin
            for (int li = 0; li < 3; li++) begin
                for (int gd = 0; gd < 2; gd++) begin
                    seg(AW'(32 + 64 * bi), AW'(16 + 112 * li), gd[0]);
                    for (int a = 0; a < 256; a += 7) begin
                        for (int s = 1; s < 8; s += 3) begin
                            req_addr = AW'(a); req_size = SZW'(s);
                            go("R7 R6 R8 sweep");
                        end
                    end
                end
            end
        end
        @(negedge clk);
        check("R1 drop", {{(AW+1){1'b0}}, rsp_valid}, '0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule